// File: doc/BRIEF.md
# Data rate and precompensation control

This block holds the data rate and write precompensation settings of a floppy disk controller. The host writes them through two write-only registers: a rate select register and a configuration control register. It gives the downstream data separator and write delay line a decoded rate code and a precompensation delay. The delay is counted in units of the finest step (about 20.8 ns), so a delay line can use the count directly with no further scaling.

The rate select register carries every field. The configuration control register carries only the rate field. The effective rate is whatever the most recent write to either register supplied. The same register also holds a manual low-power request and a software reset request. The low-power request stays set until the host touches the data register or the main status register, or until a software reset is issued. The software reset request starts a pulse of fixed length that ends on its own and leaves the stored settings as they are.

Top module: `dr_rate_ctrl`

## Requirements
- R1: After hardware reset the block reports 250 kbps (`rate_code`=2) with the default precompensation (6 steps, `pcomp_en`=1). `low_power` and `soft_rst` are both 0.
- R2: A write with `wr_sel`=0 loads the rate field from `wr_data[1:0]` and the precompensation code from `wr_data[4:2]`. Bit 5 has no effect.
- R3: A write with `wr_sel`=1 loads only the rate field from `wr_data[1:0]`. It leaves the precompensation code unchanged, and its bits 7:2 start no reset and set no low power.
- R4: The effective rate is the rate field of the most recent write to either register. It is visible in the cycle after that write.
- R5: The rate field maps to `rate_code` as follows: 00 gives 0 (500 kbps), 01 gives 1 (300 kbps), 10 gives 2 (250 kbps). Field 11 gives 3 (1 Mbps), or 4 (2 Mbps) while `hi_rate_sel` is 1.
- R6: A precompensation code n from 1 to 6 gives `pcomp_steps`=2n below 2 Mbps (n times 41.67 ns) and `pcomp_steps`=n at 2 Mbps.
- R7: Precompensation code 7 disables precompensation: `pcomp_en`=0 and `pcomp_steps`=0.
- R8: Precompensation code 0 selects the default delay. It is 6 steps (125 ns) at 500, 300 and 250 kbps, 2 steps at 1 Mbps and 1 step at 2 Mbps.
- R9: A `wr_sel`=0 write with bit 7 set drives `soft_rst` high for exactly RST_CYCLES clocks, beginning in the cycle after the write. `soft_rst` then returns to 0 on its own. The pulse does not change the stored rate or precompensation.
- R10: A `wr_sel`=0 write with bit 6 set raises `low_power` in the next cycle. A later write with bit 6 clear does not lower it.
- R11: `low_power` falls in the cycle after a `data_acc` or `stat_acc` pulse, or after a bit-7 reset write. The priority is: reset bit over bit 6, and bit 6 over an access in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| wr_en | input | 1 | Host register write strobe, one cycle |
| wr_sel | input | 1 | 0 = rate select register, 1 = configuration control register |
| wr_data | input | 8 | Host write data |
| data_acc | input | 1 | Host accessed the data register |
| stat_acc | input | 1 | Host accessed the main status register |
| hi_rate_sel | input | 1 | Rate field 11 means 2 Mbps instead of 1 Mbps |
| rate_code | output | 3 | Effective data rate code |
| pcomp_steps | output | 4 | Precompensation delay in finest-step units |
| pcomp_en | output | 1 | Precompensation active |
| low_power | output | 1 | Manual low-power state |
| soft_rst | output | 1 | Self-clearing software reset pulse |

## Verification
The bench builds the block with RST_CYCLES=4 rather than the default 5, so the pulse-length check measures the actual parameter and not a hard-wired count. The other parameters keep their defaults. With those defaults, every precompensation code can be checked against every rate, including the 2 Mbps half-step scaling. The ordering cases are driven directly: a bit-6 write that coincides with an access, and a reset bit that overrides bit 6 in the same write.

// File: rtl/dr_rate_pkg.sv
package dr_rate_pkg;

    typedef enum logic [2:0] {
        RATE_500K = 3'd0,
        RATE_300K = 3'd1,
        RATE_250K = 3'd2,
        RATE_1M   = 3'd3,
        RATE_2M   = 3'd4
    } rate_e;

    localparam logic SEL_RATE = 1'b0;
    localparam logic SEL_CFG  = 1'b1;

    localparam int RATE_FLD_W  = 2;
    localparam int PCOMP_FLD_W = 3;

    // Field positions in the rate select register
    localparam int BIT_PC_LO = 2;
    localparam int BIT_LP    = 6;
    localparam int BIT_SRST  = 7;

    localparam logic [RATE_FLD_W-1:0]  RESET_RATE  = 2'b10;
    localparam logic [PCOMP_FLD_W-1:0] RESET_PCOMP = 3'b000;
    localparam logic [PCOMP_FLD_W-1:0] PCOMP_OFF   = 3'b111;

    typedef struct packed {
        logic [RATE_FLD_W-1:0]  rate;
        logic [PCOMP_FLD_W-1:0] pcomp;
        logic                   lp;
    } ctrl_state_t;

endpackage

// File: rtl/dr_ctrl_regs.sv
module dr_ctrl_regs
    import dr_rate_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   wr_sel,
    input  logic [7:0]             wr_data,
    input  logic                   any_acc,
    output logic [RATE_FLD_W-1:0]  rate_fld,
    output logic [PCOMP_FLD_W-1:0] pcomp_fld,
    output logic                   lp_on,
    output logic                   srst_start
);

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        srst_start = 1'b0;
        if (any_acc) begin
            st_d.lp = 1'b0;
        end
        if (wr_en) begin
            st_d.rate = wr_data[RATE_FLD_W-1:0];
            if (wr_sel == SEL_RATE) begin
                st_d.pcomp = wr_data[BIT_PC_LO +: PCOMP_FLD_W];
                if (wr_data[BIT_LP]) begin
                    st_d.lp = 1'b1;
                end
                if (wr_data[BIT_SRST]) begin
                    st_d.lp    = 1'b0;
                    srst_start = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rate  <= RESET_RATE;
            st_q.pcomp <= RESET_PCOMP;
            st_q.lp    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rate_fld  = st_q.rate;
    assign pcomp_fld = st_q.pcomp;
    assign lp_on     = st_q.lp;

    // R4: rate follows the latest write of either register
    a_r4_rate_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st_q.rate == $past(wr_data[RATE_FLD_W-1:0])));

    // R3: configuration control write keeps the precompensation code
    a_r3_cfg_keeps_pcomp: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CFG) |=> $stable(st_q.pcomp));

    // R10: low power holds until an access or a reset bit
    a_r10_lp_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lp && !any_acc && !(wr_en && wr_sel == SEL_RATE && wr_data[BIT_SRST]))
        |=> st_q.lp);

    // R11: access ends low power unless the same cycle sets it
    a_r11_lp_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (any_acc && !(wr_en && wr_sel == SEL_RATE && wr_data[BIT_LP] && !wr_data[BIT_SRST]))
        |=> !st_q.lp);

endmodule

// File: rtl/dr_rst_pulse.sv
module dr_rst_pulse #(
    parameter int RST_CYCLES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);

    localparam int CNT_W = $clog2(RST_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES);
    localparam int RUN_W = 16;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CNT_LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign active = (cnt_q != '0);

    // Checker: length of the current high run of the pulse
    logic [RUN_W-1:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!active) begin
            run_q <= '0;
        end else if (run_q != {RUN_W{1'b1}}) begin
            run_q <= run_q + 1'b1;
        end
    end

    // R9: pulse never shorter than RST_CYCLES clocks
    a_r9_pulse_min_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> (run_q >= RUN_W'(RST_CYCLES)));

    // R9: a start request always produces a pulse next cycle
    a_r9_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> active);

endmodule

// File: rtl/dr_pcomp_map.sv
module dr_pcomp_map
    import dr_rate_pkg::*;
#(
    parameter int STEPS_W  = 4,
    parameter int DEF_SLOW = 6,
    parameter int DEF_1M   = 2,
    parameter int DEF_2M   = 1
) (
    input  logic [RATE_FLD_W-1:0]  rate_fld,
    input  logic [PCOMP_FLD_W-1:0] pcomp_fld,
    input  logic                   hi_rate_sel,
    output rate_e                  rate,
    output logic [STEPS_W-1:0]     steps,
    output logic                   enable
);

    always_comb begin
        unique case (rate_fld)
            2'b00:   rate = RATE_500K;
            2'b01:   rate = RATE_300K;
            2'b10:   rate = RATE_250K;
            default: rate = hi_rate_sel ? RATE_2M : RATE_1M;
        endcase
    end

    always_comb begin
        enable = 1'b1;
        steps  = '0;
        if (pcomp_fld == PCOMP_OFF) begin
            enable = 1'b0;
        end else if (pcomp_fld == '0) begin
            unique case (rate)
                RATE_2M: steps = STEPS_W'(DEF_2M);
                RATE_1M: steps = STEPS_W'(DEF_1M);
                default: steps = STEPS_W'(DEF_SLOW);
            endcase
        end else if (rate == RATE_2M) begin
            steps = STEPS_W'(pcomp_fld);
        end else begin
            steps = STEPS_W'({pcomp_fld, 1'b0});
        end
    end

endmodule

// File: rtl/dr_rate_ctrl.sv
module dr_rate_ctrl
    import dr_rate_pkg::*;
#(
    parameter int RST_CYCLES = 5,
    parameter int STEPS_W    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [7:0]         wr_data,
    input  logic               data_acc,
    input  logic               stat_acc,
    input  logic               hi_rate_sel,
    output logic [2:0]         rate_code,
    output logic [STEPS_W-1:0] pcomp_steps,
    output logic               pcomp_en,
    output logic               low_power,
    output logic               soft_rst
);

    logic [RATE_FLD_W-1:0]  rate_fld;
    logic [PCOMP_FLD_W-1:0] pcomp_fld;
    logic                   srst_start;
    rate_e                  rate;

    dr_ctrl_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .any_acc    (data_acc | stat_acc),
        .rate_fld   (rate_fld),
        .pcomp_fld  (pcomp_fld),
        .lp_on      (low_power),
        .srst_start (srst_start)
    );

    dr_rst_pulse #(
        .RST_CYCLES (RST_CYCLES)
    ) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (srst_start),
        .active (soft_rst)
    );

    dr_pcomp_map #(
        .STEPS_W (STEPS_W)
    ) u_map (
        .rate_fld    (rate_fld),
        .pcomp_fld   (pcomp_fld),
        .hi_rate_sel (hi_rate_sel),
        .rate        (rate),
        .steps       (pcomp_steps),
        .enable      (pcomp_en)
    );

    assign rate_code = rate;

    // R7: a disabled precompensation never reports a delay
    a_r7_off_no_delay: assert property (@(posedge clk) disable iff (!rst_n)
        !pcomp_en |-> (pcomp_steps == '0));

endmodule

// File: tb/dr_rate_ctrl_tb_top.sv
`timescale 1ns/1ps
module dr_rate_ctrl_tb_top;

    localparam int RST_N_CYC = 4;
    localparam int NVEC      = 13;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       data_acc = 1'b0;
    logic       stat_acc = 1'b0;
    logic       hi_rate_sel = 1'b0;
    logic [2:0] rate_code;
    logic [3:0] pcomp_steps;
    logic       pcomp_en;
    logic       low_power;
    logic       soft_rst;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    dr_rate_ctrl #(.RST_CYCLES(RST_N_CYC), .STEPS_W(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .data_acc(data_acc), .stat_acc(stat_acc), .hi_rate_sel(hi_rate_sel),
        .rate_code(rate_code), .pcomp_steps(pcomp_steps), .pcomp_en(pcomp_en),
        .low_power(low_power), .soft_rst(soft_rst)
    );

    // {req, sel, data, hi, exp_rate, exp_steps, exp_en}
    localparam logic [21:0] VEC [NVEC] = '{
        {4'd8, 1'b0, 8'h00, 1'b0, 3'd0, 4'd6,  1'b1},  // R8 500k default
        {4'd5, 1'b0, 8'h01, 1'b0, 3'd1, 4'd6,  1'b1},  // R5 300k, R8
        {4'd8, 1'b0, 8'h03, 1'b0, 3'd3, 4'd2,  1'b1},  // R8 1M default
        {4'd5, 1'b0, 8'h03, 1'b1, 3'd4, 4'd1,  1'b1},  // R5 2M, R8
        {4'd6, 1'b0, 8'h0E, 1'b0, 3'd2, 4'd6,  1'b1},  // R6 code 3 at 250k
        {4'd6, 1'b0, 8'h07, 1'b1, 3'd4, 4'd1,  1'b1},  // R6 code 1 at 2M
        {4'd6, 1'b0, 8'h18, 1'b0, 3'd0, 4'd12, 1'b1},  // R6 code 6 at 500k
        {4'd7, 1'b0, 8'h1D, 1'b0, 3'd1, 4'd0,  1'b0},  // R7 code 7
        {4'd3, 1'b1, 8'h03, 1'b0, 3'd3, 4'd0,  1'b0},  // R3 cfg keeps code 7
        {4'd3, 1'b1, 8'h3E, 1'b0, 3'd2, 4'd0,  1'b0},  // R3 upper bits ignored
        {4'd2, 1'b0, 8'h25, 1'b0, 3'd1, 4'd2,  1'b1},  // R2 bit 5 ignored
        {4'd4, 1'b1, 8'h00, 1'b0, 3'd0, 4'd2,  1'b1},  // R4 cfg sets rate last
        {4'd6, 1'b0, 8'h17, 1'b1, 3'd4, 4'd5,  1'b1}   // R6 code 5 at 2M
    };

    task automatic chk(input int req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    task automatic do_write(input logic sel, input logic [7:0] d, input logic acc);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d; data_acc = acc;
        @(negedge clk);
        wr_en = 1'b0; data_acc = 1'b0;
    endtask

    task automatic pulse_acc(input logic use_stat);
        @(negedge clk);
        if (use_stat) stat_acc = 1'b1; else data_acc = 1'b1;
        @(negedge clk);
        stat_acc = 1'b0; data_acc = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(1, "reset rate", rate_code, 2);
        chk(1, "reset steps", pcomp_steps, 6);
        chk(1, "reset en", pcomp_en, 1);
        chk(1, "reset low_power", low_power, 0);
        chk(1, "reset soft_rst", soft_rst, 0);

        for (int i = 0; i < NVEC; i++) begin
            hi_rate_sel = VEC[i][8];
            do_write(VEC[i][17], VEC[i][16:9], 1'b0);
            chk(int'(VEC[i][21:18]), "rate", rate_code, int'(VEC[i][7:5]));
            chk(int'(VEC[i][21:18]), "steps", pcomp_steps, int'(VEC[i][4:1]));
            chk(int'(VEC[i][21:18]), "en", pcomp_en, int'(VEC[i][0]));
            chk(3, "no low power from table", low_power, 0);
            chk(3, "no soft reset from table", soft_rst, 0);
        end
        hi_rate_sel = 1'b0;

        // R9 self-clearing reset, stored settings kept: code 2 at 250k
        do_write(1'b0, 8'h8A, 1'b0);
        begin
            int n;
            n = 0;
            while (soft_rst && n < 100) begin
                n++;
                @(negedge clk);
            end
            chk(9, "soft reset length", n, RST_N_CYC);
        end
        chk(9, "rate kept after reset", rate_code, 2);
        chk(9, "steps kept after reset", pcomp_steps, 4);

        // R10 set and hold
        do_write(1'b0, 8'h42, 1'b0);
        chk(10, "low power set", low_power, 1);
        do_write(1'b0, 8'h02, 1'b0);
        chk(10, "bit6 clear keeps low power", low_power, 1);
        // R11 data access clears
        pulse_acc(1'b0);
        chk(11, "data access clears", low_power, 0);
        do_write(1'b0, 8'h42, 1'b0);
        pulse_acc(1'b1);
        chk(11, "status access clears", low_power, 0);
        // R11 reset bit clears
        do_write(1'b0, 8'h42, 1'b0);
        do_write(1'b0, 8'h82, 1'b0);
        chk(11, "reset bit clears", low_power, 0);
        chk(9, "reset pulse present", soft_rst, 1);
        repeat (RST_N_CYC + 1) @(negedge clk);
        // R11 reset bit beats bit 6
        do_write(1'b0, 8'hC2, 1'b0);
        chk(11, "reset over bit6", low_power, 0);
        repeat (RST_N_CYC + 1) @(negedge clk);
        // R11 bit 6 beats a same-cycle access
        do_write(1'b0, 8'h42, 1'b1);
        chk(11, "bit6 over access", low_power, 1);
        pulse_acc(1'b0);
        // R3 cfg write with bits 7 and 6 set does nothing to them
        do_write(1'b1, 8'hC1, 1'b0);
        chk(3, "cfg bit6 ignored", low_power, 0);
        chk(3, "cfg bit7 ignored", soft_rst, 0);
        chk(4, "cfg rate", rate_code, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule